// File: doc/BRIEF.md
# L1 Cache Mode and Invalidate Controller

This block holds the mode and replacement state for one 8-way set-associative L1 cache. A three-bit control register turns the cache on, locks its contents or requests a flash invalidate. The block also stores a valid bit for every line and a 7-bit tree pseudo-LRU word for every set. The tag comparison is done elsewhere, and its match result and matching way arrive as inputs. For each accepted CPU request the block decides whether the access is served from the array, starts a burst line fill into a chosen way, or goes out as a single-beat bus transaction. It returns that decision, the chosen way and the caller's cache-inhibit attribute one cycle later.

The block also answers bus-side snoop lookups and invalidates any line that a snoop hits. A flash invalidate sweeps one set per cycle. For the whole sweep, CPU requests are stalled and snoops report a miss. Lock mode freezes the contents. Hits are still served, but misses neither allocate nor disturb the replacement state. A line removed by a snoop while the cache is locked therefore stays absent until the lock is released.

Top module: `l1_cache_ctrl`

## Requirements
- R1: After reset the control register reads 0 (bit 0 enable, bit 1 lock, bit 2 flash invalidate), busy is low, req_ready is high and every line is invalid.
- R2: While enable is 0, every accepted request returns outcome SINGLE (code 2) with way 0 and changes no state, and every snoop reports a miss and invalidates nothing.
- R3: rsp_inhibit equals the req_inhibit of the accepted request in every mode. An inhibited request returns SINGLE with way 0 and allocates nothing.
- R4: With enable set, a request whose tag match falls on a valid line returns outcome HIT (code 0) with the matching way. rsp_valid rises in the cycle after acceptance.
- R5: A miss with enable set and lock clear returns FILL (code 1) and marks the chosen line valid. The chosen way is the lowest-numbered invalid way of the set, or the pseudo-LRU victim when all eight ways are valid.
- R6: Pseudo-LRU tree nodes are numbered in heap order (children of node n are 2n+1 and 2n+2), and a node bit of 0 points to the lower half. The all-zero word therefore selects way 0. Every hit or fill sets each node on the used way's path to point away from it.
- R7: With lock set, hits are served as in R4. Misses return SINGLE with way 0 and change neither valid nor pseudo-LRU state.
- R8: With enable set and no invalidate in progress, a snoop whose match falls on a valid line reports a hit and invalidates that line. Under lock the line then misses as SINGLE until lock is cleared.
- R9: Writing the flash bit while enable is set stalls requests at once. The bit reads 0 one cycle after the write, busy then stays high for exactly 128 cycles, and afterwards every line is invalid and every pseudo-LRU word is zero.
- R10: Writing the flash bit while enable is 0 leaves it reading 1 with busy low and starts no invalidation. Clearing it by a later write leaves the stored lines intact.
- R11: While a flash invalidate is pending or in progress, snoops report a miss and req_ready is low.
- R12: When a request and a snoop fall in the same cycle, both are judged on the state before that cycle. The request's allocation is applied first and the snoop's invalidation second, so a snoop hit on the way being filled leaves that line invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | Control write value {flash, lock, enable} |
| cfg_q | output | 3 | Control register contents {flash, lock, enable} |
| busy | output | 1 | Flash invalidate sweep running |
| req_valid | input | 1 | CPU request valid |
| req_ready | output | 1 | Request can be accepted |
| req_set | input | 7 | Set index of the request |
| req_hit | input | 1 | Tag comparator reports a match |
| req_hit_way | input | 3 | Way that matched |
| req_inhibit | input | 1 | Caller's cache-inhibit attribute |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_kind | output | 2 | Outcome: 0 HIT, 1 FILL, 2 SINGLE |
| rsp_way | output | 3 | Way hit or filled (0 for SINGLE) |
| rsp_inhibit | output | 1 | Cache-inhibit attribute passed through |
| snp_valid | input | 1 | Snoop lookup valid |
| snp_set | input | 7 | Snoop set index |
| snp_hit | input | 1 | Snoop tag match |
| snp_way | input | 3 | Snoop matching way |
| snp_rsp_hit | output | 1 | Snoop hit a valid line (same cycle) |

## Verification
A CPU request and a snoop may land on the same set in one cycle. The snoop may hit the very way that the request hits or that the fill selects. Random traffic is confined to four sets so that such overlaps occur often. A directed case also fills a full set, then hits and snoops one of its ways together. The outcome is judged against a bench model that evaluates both on the prior state and applies the snoop's invalidation after the request's update. Later requests to that way must then miss.

// File: rtl/l1cc_pkg.sv
package l1cc_pkg;
    typedef enum logic [1:0] {
        OUT_HIT    = 2'd0,
        OUT_FILL   = 2'd1,
        OUT_SINGLE = 2'd2
    } out_e;

    localparam int CFG_EN   = 0;
    localparam int CFG_LOCK = 1;
    localparam int CFG_FINV = 2;
    localparam int CFG_W    = 3;
endpackage

// File: rtl/l1cc_plru_victim.sv
module l1cc_plru_victim #(
    parameter int WAYS = 8,
    localparam int WAY_W = $clog2(WAYS),
    localparam int TREE_W = WAYS - 1
) (
    input  logic [TREE_W-1:0] tree_i,
    output logic [WAY_W-1:0]  victim_o
);
    logic [WAY_W-1:0] pre;
    logic [WAY_W-1:0] idx;

    always_comb begin
        pre = '0;
        idx = '0;
        for (int l = 0; l < WAY_W; l++) begin
            idx = WAY_W'((1 << l) - 1) + pre;
            pre = (pre << 1) | WAY_W'(tree_i[idx]);
        end
        victim_o = pre;
    end
endmodule

// File: rtl/l1cc_plru_touch.sv
module l1cc_plru_touch #(
    parameter int WAYS = 8,
    localparam int WAY_W = $clog2(WAYS),
    localparam int TREE_W = WAYS - 1
) (
    input  logic [TREE_W-1:0] tree_i,
    input  logic [WAY_W-1:0]  way_i,
    output logic [TREE_W-1:0] tree_o
);
    logic [WAY_W-1:0] pre;
    logic [WAY_W-1:0] idx;
    logic             dir;

    always_comb begin
        tree_o = tree_i;
        pre    = '0;
        idx    = '0;
        dir    = 1'b0;
        for (int l = 0; l < WAY_W; l++) begin
            idx         = WAY_W'((1 << l) - 1) + pre;
            dir         = way_i[WAY_W-1-l];
            tree_o[idx] = ~dir;
            pre         = (pre << 1) | WAY_W'(dir);
        end
    end
endmodule

// File: rtl/l1cc_way_pick.sv
module l1cc_way_pick #(
    parameter int WAYS = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  valid_i,
    input  logic [WAY_W-1:0] victim_i,
    output logic [WAY_W-1:0] way_o
);
    always_comb begin
        way_o = victim_i;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_i[w]) way_o = WAY_W'(w);
        end
    end
endmodule

// File: rtl/l1_cache_ctrl.sv
module l1_cache_ctrl
    import l1cc_pkg::*;
#(
    parameter int SETS = 128,
    parameter int WAYS = 8,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int TREE_W = WAYS - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_q,
    output logic              busy,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SET_W-1:0]  req_set,
    input  logic              req_hit,
    input  logic [WAY_W-1:0]  req_hit_way,
    input  logic              req_inhibit,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [WAY_W-1:0]  rsp_way,
    output logic              rsp_inhibit,
    input  logic              snp_valid,
    input  logic [SET_W-1:0]  snp_set,
    input  logic              snp_hit,
    input  logic [WAY_W-1:0]  snp_way,
    output logic              snp_rsp_hit
);
    typedef struct packed {
        logic                              en;
        logic                              lock;
        logic                              finv;
        logic                              busy;
        logic [SET_W-1:0]                  sweep;
        logic [SETS-1:0][WAYS-1:0]         valid;
        logic [SETS-1:0][TREE_W-1:0]       plru;
        logic                              rsp_v;
        out_e                              kind;
        logic [WAY_W-1:0]                  way;
        logic                              inh;
    } state_t;

    state_t st_q, st_d;

    logic              inv_active;
    logic              accept;
    logic [WAYS-1:0]   row;
    logic [TREE_W-1:0] tree;
    logic              line_hit;
    logic [WAY_W-1:0]  victim;
    logic [WAY_W-1:0]  fill_way;
    logic [WAY_W-1:0]  touch_way;
    logic [TREE_W-1:0] tree_new;

    assign inv_active = st_q.busy | (st_q.finv & st_q.en);
    assign req_ready  = ~inv_active;
    assign accept     = req_valid & req_ready;
    assign row        = st_q.valid[req_set];
    assign tree       = st_q.plru[req_set];
    assign line_hit   = req_hit & row[req_hit_way];
    assign touch_way  = line_hit ? req_hit_way : fill_way;

    l1cc_plru_victim #(.WAYS(WAYS)) i_victim (
        .tree_i   (tree),
        .victim_o (victim)
    );

    l1cc_way_pick #(.WAYS(WAYS)) i_pick (
        .valid_i  (row),
        .victim_i (victim),
        .way_o    (fill_way)
    );

    l1cc_plru_touch #(.WAYS(WAYS)) i_touch (
        .tree_i   (tree),
        .way_i    (touch_way),
        .tree_o   (tree_new)
    );

    assign snp_rsp_hit = snp_valid & st_q.en & ~inv_active & snp_hit
                       & st_q.valid[snp_set][snp_way];

    always_comb begin
        st_d       = st_q;
        st_d.rsp_v = accept;

        // CPU request outcome, judged on the state before this cycle
        if (accept) begin
            st_d.inh = req_inhibit;
            if (!st_q.en || req_inhibit) begin
                st_d.kind = OUT_SINGLE;
                st_d.way  = '0;
            end else if (line_hit) begin
                st_d.kind          = OUT_HIT;
                st_d.way           = req_hit_way;
                st_d.plru[req_set] = tree_new;
            end else if (st_q.lock) begin
                st_d.kind = OUT_SINGLE;
                st_d.way  = '0;
            end else begin
                st_d.kind                     = OUT_FILL;
                st_d.way                      = fill_way;
                st_d.valid[req_set][fill_way] = 1'b1;
                st_d.plru[req_set]            = tree_new;
            end
        end

        // Snoop invalidation lands after the request's allocation
        if (snp_rsp_hit) begin
            st_d.valid[snp_set][snp_way] = 1'b0;
        end

        // Flash invalidate: start on pending bit, then one set per cycle
        if (st_q.busy) begin
            st_d.valid[st_q.sweep] = '0;
            st_d.plru[st_q.sweep]  = '0;
            st_d.sweep             = st_q.sweep + 1'b1;
            if (st_q.sweep == SET_W'(SETS - 1)) st_d.busy = 1'b0;
        end else if (st_q.finv && st_q.en) begin
            st_d.finv  = 1'b0;
            st_d.busy  = 1'b1;
            st_d.sweep = '0;
        end

        if (cfg_we) begin
            st_d.en   = cfg_wdata[CFG_EN];
            st_d.lock = cfg_wdata[CFG_LOCK];
            st_d.finv = cfg_wdata[CFG_FINV];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_q       = {st_q.finv, st_q.lock, st_q.en};
    assign busy        = st_q.busy;
    assign rsp_valid   = st_q.rsp_v;
    assign rsp_kind    = st_q.kind;
    assign rsp_way     = st_q.way;
    assign rsp_inhibit = st_q.inh;
endmodule

// File: rtl/l1cc_chk.sv
module l1cc_chk #(
    parameter int SETS = 128
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [2:0] cfg_q,
    input logic       busy,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_inhibit,
    input logic       rsp_valid,
    input logic [1:0] rsp_kind,
    input logic       rsp_inhibit,
    input logic       snp_rsp_hit
);
    int unsigned busy_len;

    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    AST_DISABLED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !cfg_q[0]) |=> (rsp_valid && rsp_kind == 2'd2)); // R2

    AST_INHIBIT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_inhibit == $past(req_inhibit))); // R3

    AST_LOCK_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && cfg_q[1] && !cfg_we) |=> (rsp_kind != 2'd1)); // R7

    AST_FLASH_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[2] && cfg_q[0] && !busy && !cfg_we) |=> (!cfg_q[2] && busy)); // R9

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == SETS)); // R9

    AST_FLASH_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[2] && !cfg_q[0] && !cfg_we) |=> (cfg_q[2] && !busy)); // R10

    AST_SWEEP_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!req_ready && !snp_rsp_hit)); // R11
endmodule

bind l1_cache_ctrl l1cc_chk #(.SETS(SETS)) i_l1cc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_q       (cfg_q),
    .busy        (busy),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_inhibit (req_inhibit),
    .rsp_valid   (rsp_valid),
    .rsp_kind    (rsp_kind),
    .rsp_inhibit (rsp_inhibit),
    .snp_rsp_hit (snp_rsp_hit)
);

// File: tb/test_l1_cache_ctrl.sv
module test_l1_cache_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_wdata = '0;
    logic [2:0] cfg_q;
    logic       busy;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [6:0] req_set = '0;
    logic       req_hit = 1'b0;
    logic [2:0] req_hit_way = '0;
    logic       req_inhibit = 1'b0;
    logic       rsp_valid;
    logic [1:0] rsp_kind;
    logic [2:0] rsp_way;
    logic       rsp_inhibit;
    logic       snp_valid = 1'b0;
    logic [6:0] snp_set = '0;
    logic       snp_hit = 1'b0;
    logic [2:0] snp_way = '0;
    logic       snp_rsp_hit;

    always #5 clk = ~clk;

    l1_cache_ctrl i_l1_cache_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_q(cfg_q), .busy(busy), .req_valid(req_valid), .req_ready(req_ready),
        .req_set(req_set), .req_hit(req_hit), .req_hit_way(req_hit_way),
        .req_inhibit(req_inhibit), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
        .rsp_way(rsp_way), .rsp_inhibit(rsp_inhibit), .snp_valid(snp_valid),
        .snp_set(snp_set), .snp_hit(snp_hit), .snp_way(snp_way),
        .snp_rsp_hit(snp_rsp_hit)
    );

    int  tests = 0;
    int  fails = 0;
    bit  done = 1'b0;
    bit  m_en = 1'b0;
    bit  m_lock = 1'b0;
    bit  m_valid [128][8];
    bit [6:0] m_plru [128];
    int  last_kind;
    int  last_way;

    task automatic chk(input bit ok, input string tg, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tg, what, act, exp);
        end
    endtask

    function automatic int plru_victim(input bit [6:0] t);
        int node = 0;
        int v = 0;
        for (int l = 0; l < 3; l++) begin
            v    = v * 2 + int'(t[node]);
            node = 2 * node + 1 + int'(t[node]);
        end
        return v;
    endfunction

    function automatic bit [6:0] plru_touch(input bit [6:0] t, input int w);
        int node = 0;
        bit b;
        for (int l = 0; l < 3; l++) begin
            b       = w[2-l];
            t[node] = ~b;
            node    = 2 * node + 1 + int'(b);
        end
        return t;
    endfunction

    function automatic int pick_way(input int s);
        for (int w = 0; w < 8; w++) if (!m_valid[s][w]) return w;
        return plru_victim(m_plru[s]);
    endfunction

    task automatic model_clear();
        for (int s = 0; s < 128; s++) begin
            m_plru[s] = '0;
            for (int w = 0; w < 8; w++) m_valid[s][w] = 1'b0;
        end
    endtask

    task automatic wcfg(input bit [2:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        m_en = v[0];
        m_lock = v[1];
    endtask

    task automatic cyc(input bit rv, input int rs, input bit rh, input int rw,
                       input bit ri, input bit sv, input int ss, input bit sh,
                       input int sw);
        bit exp_snp;
        bit lh;
        int ek;
        int ew;
        string tg;
        req_valid = rv; req_set = rs[6:0]; req_hit = rh; req_hit_way = rw[2:0];
        req_inhibit = ri;
        snp_valid = sv; snp_set = ss[6:0]; snp_hit = sh; snp_way = sw[2:0];
        #1;
        chk(req_ready == 1'b1, "R11", "ready with no flash", int'(req_ready), 1);
        exp_snp = sv && m_en && sh && m_valid[ss][sw];
        if (sv) chk(snp_rsp_hit == exp_snp, m_en ? "R8" : "R2", "snoop hit",
                    int'(snp_rsp_hit), int'(exp_snp));
        lh = rh && m_valid[rs][rw];
        if (!m_en)      begin ek = 2; ew = 0; tg = "R2"; end
        else if (ri)    begin ek = 2; ew = 0; tg = "R3"; end
        else if (lh)    begin ek = 0; ew = rw; tg = "R4"; end
        else if (m_lock) begin ek = 2; ew = 0; tg = "R7"; end
        else            begin ek = 1; ew = pick_way(rs); tg = "R5"; end
        @(posedge clk);
        @(negedge clk);
        if (rv) begin
            chk(rsp_valid == 1'b1, "R4", "rsp_valid", int'(rsp_valid), 1);
            chk(int'(rsp_kind) == ek, tg, "outcome", int'(rsp_kind), ek);
            chk(int'(rsp_way) == ew, tg, "way", int'(rsp_way), ew);
            chk(rsp_inhibit == ri, "R3", "inhibit pass", int'(rsp_inhibit), int'(ri));
            last_kind = int'(rsp_kind);
            last_way = int'(rsp_way);
            if (ek == 0) m_plru[rs] = plru_touch(m_plru[rs], rw);
            if (ek == 1) begin
                m_valid[rs][ew] = 1'b1;
                m_plru[rs] = plru_touch(m_plru[rs], ew);
            end
        end else begin
            chk(rsp_valid == 1'b0, "R4", "no rsp when idle", int'(rsp_valid), 0);
        end
        if (exp_snp) m_valid[ss][sw] = 1'b0;
        req_valid = 1'b0;
        snp_valid = 1'b0;
    endtask

    task automatic rnd_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            int rs = int'($urandom % 4);
            int ss = int'($urandom % 4);
            int rw = int'($urandom % 8);
            int sw = int'($urandom % 8);
            bit rh = ($urandom % 10) < 7;
            bit sh = ($urandom % 2) == 1;
            for (int k = 0; k < 8; k++) begin
                if (m_valid[rs][(rw + k) % 8]) begin rw = (rw + k) % 8; break; end
            end
            for (int k = 0; k < 8; k++) begin
                if (m_valid[ss][(sw + k) % 8]) begin sw = (sw + k) % 8; break; end
            end
            cyc(($urandom % 4) != 0, rs, rh, rw, ($urandom % 8) == 0,
                ($urandom % 4) == 0, ss, sh, sw);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int cnt;
        void'($urandom(32'd7));
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(cfg_q == 3'b000, "R1", "cfg after reset", int'(cfg_q), 0);
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);

        // R2 disabled: single beats, snoops ignored
        rnd_cycles(40);

        // enable and run mixed random traffic (R3..R6, R8, R12)
        wcfg(3'b001);
        cyc(1, 1, 0, 0, 0, 0, 0, 0, 0);
        chk(last_kind == 1 && last_way == 0, "R1", "first fill lands in way 0 (lines invalid)",
            last_kind * 8 + last_way, 8);
        rnd_cycles(3000);

        // R7/R8 lock directed
        cyc(1, 30, 0, 0, 0, 0, 0, 0, 0);
        wcfg(3'b011);
        cyc(1, 30, 1, 0, 0, 0, 0, 0, 0);
        chk(last_kind == 0, "R7", "locked hit served", last_kind, 0);
        cyc(1, 31, 0, 0, 0, 0, 0, 0, 0);
        chk(last_kind == 2, "R7", "locked miss single", last_kind, 2);
        cyc(0, 0, 0, 0, 0, 1, 30, 1, 0);
        cyc(1, 30, 1, 0, 0, 0, 0, 0, 0);
        chk(last_kind == 2, "R8", "snooped line stays out under lock", last_kind, 2);
        rnd_cycles(500);
        wcfg(3'b001);
        cyc(1, 30, 1, 0, 0, 0, 0, 0, 0);
        chk(last_kind == 1, "R8", "refill after unlock", last_kind, 1);

        // R10 flash with cache disabled
        cyc(1, 20, 0, 0, 0, 0, 0, 0, 0);
        wcfg(3'b100);
        repeat (5) @(negedge clk);
        chk(cfg_q == 3'b100, "R10", "flash bit held while disabled", int'(cfg_q), 4);
        chk(busy == 1'b0, "R10", "no sweep while disabled", int'(busy), 0);
        cyc(1, 20, 1, 0, 0, 0, 0, 0, 0);
        wcfg(3'b001);
        cyc(1, 20, 1, 0, 0, 0, 0, 0, 0);
        chk(last_kind == 0, "R10", "line kept after disabled flash", last_kind, 0);

        // R12 directed: fill set 9 fully, then hit and snoop way 3 together
        for (int w = 0; w < 8; w++) cyc(1, 9, 0, 0, 0, 0, 0, 0, 0);
        cyc(1, 9, 1, 3, 0, 1, 9, 1, 3);
        chk(last_kind == 0 && last_way == 3, "R12", "hit judged on prior state",
            last_kind * 8 + last_way, 3);
        cyc(1, 9, 1, 3, 0, 0, 0, 0, 0);
        chk(last_kind == 1 && last_way == 3, "R12", "snooped way refilled",
            last_kind * 8 + last_way, 11);

        // R9/R11 flash with cache enabled
        cfg_we = 1'b1;
        cfg_wdata = 3'b101;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        chk(req_ready == 1'b0, "R9", "stall while flash pending", int'(req_ready), 0);
        snp_valid = 1'b1; snp_set = 7'd9; snp_hit = 1'b1; snp_way = 3'd3;
        #1;
        chk(snp_rsp_hit == 1'b0, "R11", "snoop miss while pending", int'(snp_rsp_hit), 0);
        @(posedge clk);
        @(negedge clk);
        chk(cfg_q[2] == 1'b0, "R9", "flash bit self clears", int'(cfg_q[2]), 0);
        cnt = 0;
        while (busy && cnt < 1000) begin
            #1;
            if (cnt == 5) begin
                chk(req_ready == 1'b0, "R11", "stall during sweep", int'(req_ready), 0);
                chk(snp_rsp_hit == 1'b0, "R11", "snoop miss during sweep",
                    int'(snp_rsp_hit), 0);
            end
            cnt++;
            @(negedge clk);
        end
        snp_valid = 1'b0;
        chk(cnt == 128, "R9", "busy length", cnt, 128);
        model_clear();
        cyc(1, 9, 1, 3, 0, 0, 0, 0, 0);
        chk(last_kind == 1 && last_way == 0, "R9", "line gone after flash",
            last_kind * 8 + last_way, 8);

        // R5/R6 directed: first-free order then pseudo-LRU victim
        for (int w = 0; w < 8; w++) begin
            cyc(1, 40, 0, 0, 0, 0, 0, 0, 0);
            chk(last_way == w, "R5", "first free way", last_way, w);
        end
        cyc(1, 40, 1, 0, 0, 0, 0, 0, 0);
        cyc(1, 40, 0, 0, 0, 0, 0, 0, 0);
        chk(last_kind == 1 && last_way == 4, "R6", "victim after touching way 0",
            last_kind * 8 + last_way, 12);
        rnd_cycles(1000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule